// File: doc/BRIEF.md
# Heartbeat Watchdog with Safe Frequency Fallback

The block watches a heartbeat that software supplies by writing the watchdog count register. Once armed, it counts time-base ticks. Each tick stands for one unit interval, nominally 290 ms. If no count write arrives within the programmed number of ticks, the block enters an alarm state. In that state it raises a sticky status flag and drives an active-low system reset pulse. It also forces the frequency-select code toward the synthesizer to a safe value.

The safe code comes from one of two sources, chosen by a mode bit: the hardware select pins latched at power-on, or a programmable safe-code register. While no alarm is pending, the normal select code passes straight through to the output. The interval is the count value multiplied by the unit interval. The power-up count of 8 gives about 2.3 s. The register bus and the synthesizer itself sit outside this block. Register writes arrive as plain write strobes with data.

Top module: `wdog_safe_freq`

## Requirements
- R1: After reset the watchdog is disarmed, alarm_o is 0, rst_no is 1, and freq_sel_o equals norm_sel_i. The reset values of the registers are: count 8, safe code 5'b01111, mode 0.
- R2: While disarmed (ctl bit1 = 0), ticks never raise the alarm.
- R3: While armed and not in alarm, alarm_o rises in the cycle after the N-th tick counted since the last reload, where N is the count value. A count of 0 acts as 1.
- R4: A count write (cnt_we_i) stores the new count and restarts the interval from it. This write is the heartbeat. A count write in the same cycle as the terminal tick prevents the timeout.
- R5: alarm_o is sticky. It clears only on a control write with bit0 = 0, or on reset. A control write with bit0 = 1 leaves it set.
- R6: On a timeout, rst_no goes low in the same cycle as alarm_o rises. It stays low until RST_TICKS further ticks have passed, then returns high.
- R7: Control bit2 is the mode bit and selects the source of the safe code. With mode 0 the code is hw_sel_i. With mode 1 it is the safe-code register, written through safe_we_i and safe_wdata_i.
- R8: While alarm_o is 1, freq_sel_o equals the selected safe code. Otherwise it equals norm_sel_i.
- R9: The interval counter is halted while the alarm is set, so no second reset pulse occurs. After the alarm clears, timing restarts from the full stored count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per unit interval |
| cnt_we_i | input | 1 | Count register write strobe (heartbeat) |
| cnt_wdata_i | input | CNT_W | Count value, in unit intervals |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 3 | bit2 mode, bit1 arm, bit0 alarm keep (0 clears the alarm) |
| safe_we_i | input | 1 | Safe-code register write strobe |
| safe_wdata_i | input | 5 | Programmed safe code |
| hw_sel_i | input | 5 | Select code latched from pins at power-on |
| norm_sel_i | input | 5 | Normal select code |
| freq_sel_o | output | 5 | Active frequency select |
| alarm_o | output | 1 | Sticky alarm status |
| rst_no | output | 1 | System reset, active low |

## Verification
If the interval counter holds a wrong value, alarm_o and rst_no change on the wrong tick. The bench therefore sees the error on the first timeout after the fault, within one count interval. A lost sticky bit or a wrong alarm state shows up at once on freq_sel_o, because the output falls back to norm_sel_i or leaves it. Every cycle is compared against a reference model. A fault in the pulse length shows up at the tick where rst_no should have returned high.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned SEL_W = 5;
  localparam logic [SEL_W-1:0] SAFE_RST = 5'b01111;

  // control register fields (bit2 mode, bit1 arm, bit0 alarm keep)
  typedef struct packed {
    logic mode;
    logic arm;
    logic keep;
  } ctl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CNT_RST = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             ctl_we_i,
  input  ctl_t             ctl_wdata_i,
  input  logic             safe_we_i,
  input  logic [SEL_W-1:0] safe_wdata_i,
  input  logic             timeout_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             arm_o,
  output logic             mode_o,
  output logic [SEL_W-1:0] safe_o,
  output logic             alarm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= CNT_W'(CNT_RST);
      arm_o   <= 1'b0;
      mode_o  <= 1'b0;
      safe_o  <= SAFE_RST;
      alarm_o <= 1'b0;
    end else begin
      if (cnt_we_i)  cnt_o  <= cnt_wdata_i;
      if (safe_we_i) safe_o <= safe_wdata_i;
      if (ctl_we_i) begin
        arm_o  <= ctl_wdata_i.arm;
        mode_o <= ctl_wdata_i.mode;
      end
      // set wins over a clear in the same cycle
      if (timeout_i)                        alarm_o <= 1'b1;
      else if (ctl_we_i && !ctl_wdata_i.keep) alarm_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             timeout_o
);
  logic [CNT_W-1:0] rem_q;

  assign timeout_o = active_i && tick_i && !reload_i && (rem_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rem_q <= '0;
    else if (reload_i)          rem_q <= reload_val_i;
    else if (!active_i)         rem_q <= cnt_i;
    else if (timeout_o)         rem_q <= cnt_i;
    else if (tick_i)            rem_q <= rem_q - CNT_W'(1);
  end
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int unsigned RST_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic tick_i,
  output logic rst_no
);
  localparam int unsigned PW = $clog2(RST_TICKS + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   left_q <= '0;
    else if (fire_i)               left_q <= PW'(RST_TICKS);
    else if (tick_i && left_q != 0) left_q <= left_q - PW'(1);
  end

  assign rst_no = (left_q == '0);
endmodule

// File: rtl/wdog_safe_freq.sv
module wdog_safe_freq
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned CNT_RST   = 8,
  parameter int unsigned RST_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             ctl_we_i,
  input  logic [2:0]       ctl_wdata_i,
  input  logic             safe_we_i,
  input  logic [4:0]       safe_wdata_i,
  input  logic [4:0]       hw_sel_i,
  input  logic [4:0]       norm_sel_i,
  output logic [4:0]       freq_sel_o,
  output logic             alarm_o,
  output logic             rst_no
);
  logic [CNT_W-1:0] cnt_q;
  logic             arm_q, mode_q, alarm_q, timeout;
  logic [SEL_W-1:0] safe_q, safe_code;

  wdog_regs #(.CNT_W(CNT_W), .CNT_RST(CNT_RST)) u_regs (
    .clk_i, .rst_ni, .cnt_we_i, .cnt_wdata_i, .ctl_we_i,
    .ctl_wdata_i (ctl_t'(ctl_wdata_i)),
    .safe_we_i, .safe_wdata_i,
    .timeout_i (timeout),
    .cnt_o (cnt_q), .arm_o (arm_q), .mode_o (mode_q),
    .safe_o (safe_q), .alarm_o (alarm_q)
  );

  wdog_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .active_i     (arm_q && !alarm_q),
    .tick_i,
    .reload_i     (cnt_we_i),
    .reload_val_i (cnt_wdata_i),
    .cnt_i        (cnt_q),
    .timeout_o    (timeout)
  );

  wdog_rst_pulse #(.RST_TICKS(RST_TICKS)) u_pulse (
    .clk_i, .rst_ni, .fire_i (timeout), .tick_i, .rst_no
  );

  assign safe_code  = mode_q ? safe_q : hw_sel_i;
  assign freq_sel_o = alarm_q ? safe_code : norm_sel_i;
  assign alarm_o    = alarm_q;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       ctl_we_i,
  input logic [2:0] ctl_wdata_i,
  input logic [4:0] norm_sel_i,
  input logic [4:0] freq_sel_o,
  input logic       alarm_o,
  input logic       rst_no
);
  // R5
  alarm_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alarm_o) |-> $past(ctl_we_i && !ctl_wdata_i[0]));
  // R3
  tick_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> $past(tick_i));
  // R6
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_no) |-> $rose(alarm_o));
  // R6
  rst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_no && !tick_i) |=> !rst_no);
  // R8
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alarm_o |-> freq_sel_o == norm_sel_i);
  // R9
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && $past(alarm_o)) |-> !$fell(rst_no));
endmodule

bind wdog_safe_freq wdog_chk u_chk (
  .clk_i, .rst_ni, .tick_i, .ctl_we_i, .ctl_wdata_i,
  .norm_sel_i, .freq_sel_o, .alarm_o, .rst_no
);

// File: tb/sim_wdog_safe_freq.sv
module sim_wdog_safe_freq;
  localparam int RST_TICKS = 4;

  logic clk_i = 0, rst_ni = 0;
  logic tick_i = 0, cnt_we_i = 0, ctl_we_i = 0, safe_we_i = 0;
  logic [7:0] cnt_wdata_i = 0;
  logic [2:0] ctl_wdata_i = 0;
  logic [4:0] safe_wdata_i = 0, hw_sel_i = 0, norm_sel_i = 0;
  logic [4:0] freq_sel_o;
  logic alarm_o, rst_no;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  int m_cnt = 8, m_rem = 0, m_pulse = 0;
  bit m_arm = 0, m_mode = 0, m_alarm = 0;
  logic [4:0] m_safe = 5'b01111;

  always #5 clk_i = ~clk_i;

  wdog_safe_freq u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_sel();
    if (!m_alarm) return norm_sel_i;
    return m_mode ? m_safe : hw_sel_i;
  endfunction

  task automatic model_update();
    bit active, to;
    active = m_arm && !m_alarm;
    to = active && tick_i && !cnt_we_i && (m_rem <= 1);
    if (to) m_pulse = RST_TICKS;
    else if (tick_i && m_pulse != 0) m_pulse--;
    if (cnt_we_i) m_rem = cnt_wdata_i;
    else if (!active || to) m_rem = m_cnt;
    else if (tick_i) m_rem--;
    if (cnt_we_i) m_cnt = cnt_wdata_i;
    if (safe_we_i) m_safe = safe_wdata_i;
    if (to) m_alarm = 1;
    else if (ctl_we_i && !ctl_wdata_i[0]) m_alarm = 0;
    if (ctl_we_i) begin m_arm = ctl_wdata_i[1]; m_mode = ctl_wdata_i[2]; end
  endtask

  task automatic compare();
    chk("R3 R5 R9 alarm", alarm_o, m_alarm);
    chk("R6 rst", rst_no, m_pulse == 0);
    chk("R7 R8 freq", freq_sel_o, exp_sel());
  endtask

  // called at a negedge: drive, clock, model, sample at next negedge
  task automatic step(input bit tk, input bit cw = 0, input int cd = 0,
                      input bit kw = 0, input int kd = 0);
    tick_i = tk; cnt_we_i = cw; cnt_wdata_i = 8'(cd);
    ctl_we_i = kw; ctl_wdata_i = 3'(kd);
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    tick_i = 0; cnt_we_i = 0; ctl_we_i = 0; safe_we_i = 0;
    compare();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin step(1); step(0); end
  endtask

  initial begin
    void'($urandom(32'd20417));
    norm_sel_i = 5'h02; hw_sel_i = 5'h13;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    chk("R1 alarm", alarm_o, 0);
    chk("R1 rst", rst_no, 1);
    chk("R1 freq", freq_sel_o, 5'h02);
    // R2 disarmed
    ticks(20);
    chk("R2 no alarm disarmed", alarm_o, 0);
    // arm, mode 1 (default safe register), default count 8
    step(0, 0, 0, 1, 3'b110);
    ticks(7);
    chk("R3 no alarm after 7", alarm_o, 0);
    step(1);
    chk("R3 alarm on 8th", alarm_o, 1);
    chk("R1 safe reset code", freq_sel_o, 5'b01111);
    chk("R6 rst low", rst_no, 0);
    step(0);
    ticks(3);
    chk("R6 still low", rst_no, 0);
    ticks(1);
    chk("R6 released", rst_no, 1);
    ticks(20);
    chk("R9 no repulse", rst_no, 1);
    step(0, 0, 0, 1, 3'b111);
    chk("R5 keep write", alarm_o, 1);
    step(0, 0, 0, 1, 3'b010);
    chk("R5 cleared", alarm_o, 0);
    chk("R8 pass", freq_sel_o, 5'h02);
    // R4 heartbeat
    step(0, 1, 3);
    ticks(2);
    step(0, 1, 3);
    ticks(2);
    chk("R4 heartbeat held off", alarm_o, 0);
    step(1, 1, 3);
    chk("R4 write beats terminal tick", alarm_o, 0);
    ticks(2);
    step(1);
    chk("R7 hw safe", freq_sel_o, 5'h13);
    // R3 count 0
    step(0, 1, 0, 1, 3'b010);
    step(1);
    chk("R3 zero count", alarm_o, 1);
    // mixed random
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 30) == 0) norm_sel_i = 5'($urandom);
      if ($urandom_range(0, 50) == 0) hw_sel_i = 5'($urandom);
      if ($urandom_range(0, 60) == 0) begin
        safe_we_i = 1; safe_wdata_i = 5'($urandom);
      end
      step($urandom_range(0, 3) == 0,
           $urandom_range(0, 40) == 0, $urandom_range(0, 5),
           $urandom_range(0, 50) == 0,
           {1'($urandom), ($urandom_range(0, 7) != 0), 1'($urandom)});
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule